// File: doc/BRIEF.md
# DMA Nested-Loop Address Generator

This block produces the source and destination addresses for one DMA channel that runs two nested loops. The inner loop moves a programmed number of bytes, one transfer at a time. The outer loop runs the inner loop a programmed number of times. The source side and the destination side are handled separately. Each side has its own start address, transfer width, signed step, modulo window and end-of-run adjustment. These settings let one side step through memory while the other stays on a fixed peripheral register or circles through a power-of-two ring buffer.

A load strobe captures a full descriptor and places both addresses at their start values. After that, every pulse on `xfer_done` reports that one transfer has finished. On that pulse the block moves both addresses forward and counts the bytes moved in the current inner loop. It raises `minor_done` when an inner loop completes and `major_done` when the last outer iteration ends. If the descriptor is inconsistent, the block raises `cfg_err` and does not move. The block does not perform bus transfers and does not store descriptors.

Top module: `dma_addr_gen`

## Requirements
- R1: Reset clears both addresses and `minor_done`, `major_done` and `cfg_err` to zero. Until a valid descriptor is loaded, `xfer_done` changes nothing.
- R2: When `load` is sampled high, both addresses equal their start inputs after that same edge, and both done flags read zero.
- R3: On each accepted transfer that is not the last transfer of the outer loop, each side adds its sign-extended 16-bit step to its address, modulo 2^32.
- R4: If a side's 5-bit modulo field M is nonzero, an accepted step changes only address bits [M-1:0]. Those bits wrap modulo 2^M, and bits [31:M] keep their values.
- R5: Each accepted transfer adds the source transfer width (in bytes) to an inner byte count. The transfer that brings the count to the programmed byte count raises `minor_done` for the cycle after that edge and resets the count.
- R6: Each completed inner loop decrements the iteration count. The inner loop that brings the count to zero also raises `major_done`, for one cycle only, in the same cycle as `minor_done`.
- R7: On the final transfer of the outer loop, each side adds its full 32-bit signed end adjustment in place of its step. The modulo setting does not apply to this addition.
- R8: Width codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. `cfg_err` is set at load when any of these holds: either width code is 3, the byte count is zero, the byte count is not a multiple of either side's width, or the iteration count is zero.
- R9: Once the outer loop has finished, or while `cfg_err` is set, `xfer_done` is ignored. Both addresses hold and no done flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture descriptor and restart |
| src_start_i | input | 32 | Source start address |
| src_size_i | input | 2 | Source transfer width code |
| src_step_i | input | 16 | Source signed per-transfer step |
| src_mod_i | input | 5 | Source modulo bit count (0 = off) |
| src_last_i | input | 32 | Source signed end adjustment |
| dst_start_i | input | 32 | Destination start address |
| dst_size_i | input | 2 | Destination transfer width code |
| dst_step_i | input | 16 | Destination signed per-transfer step |
| dst_mod_i | input | 5 | Destination modulo bit count (0 = off) |
| dst_last_i | input | 32 | Destination signed end adjustment |
| nbytes_i | input | 16 | Bytes per inner loop |
| iter_i | input | 16 | Outer loop iteration count |
| xfer_done | input | 1 | One transfer has completed |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |
| minor_done | output | 1 | Inner loop completed |
| major_done | output | 1 | Outer loop completed |
| cfg_err | output | 1 | Descriptor inconsistent |

## Verification
Every result is registered. The address update, the done flags and the error flag caused by a `load` or `xfer_done` sampled at a rising edge are all visible directly after that edge, with no further latency. The bench changes inputs on the falling edge and checks outputs on the next falling edge, exactly one rising edge later. This puts each comparison in the first cycle the result is due and before the following stimulus can alter it. Ignored transfers are checked the same way: the addresses and flags are read one edge after the pulse that should have had no effect.

// File: rtl/dma_ag_pkg.sv
`timescale 1ns/1ps
package dma_ag_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  // Byte count of one transfer; zero marks an illegal code.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (xfer_size_e'(code))
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      SZ_WORD: size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_ag_side.sv
`timescale 1ns/1ps
module dma_ag_side #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int MOD_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [OFF_W-1:0]  step_i,
  input  logic [MOD_W-1:0]  mod_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic              adv_i,
  input  logic              final_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [OFF_W-1:0]  step_q;
  logic [MOD_W-1:0]  mod_q;
  logic [ADDR_W-1:0] last_q;
  logic [ADDR_W-1:0] keep_mask, sum, wrapped, adjusted;

  always_comb begin
    keep_mask = (mod_q == '0) ? '0 : ({ADDR_W{1'b1}} << mod_q);
    sum       = addr_q + {{EXT_W{step_q[OFF_W-1]}}, step_q};
    wrapped   = (addr_q & keep_mask) | (sum & ~keep_mask);
    adjusted  = addr_q + last_q;
    addr_d    = addr_q;
    if (load)        addr_d = start_i;
    else if (adv_i)  addr_d = final_i ? adjusted : wrapped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= '0;
      mod_q  <= '0;
      last_q <= '0;
    end else begin
      addr_q <= addr_d;
      if (load) begin
        step_q <= step_i;
        mod_q  <= mod_i;
        last_q <= last_i;
      end
    end
  end

  assign addr_o = addr_q;

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_i) |=> $stable(addr_o));

  // R4
  mod_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_i && !final_i && mod_q != '0)
      |=> ((addr_o >> $past(mod_q)) == ($past(addr_o) >> $past(mod_q))));
endmodule

// File: rtl/dma_ag_loop.sv
`timescale 1ns/1ps
module dma_ag_loop
  import dma_ag_pkg::*;
#(
  parameter int NB_W = 16,
  parameter int IT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [1:0]      ssize_i,
  input  logic [1:0]      dsize_i,
  input  logic [NB_W-1:0] nbytes_i,
  input  logic [IT_W-1:0] iter_i,
  input  logic            xfer_done_i,
  output logic            adv_o,
  output logic            final_o,
  output logic            minor_done_o,
  output logic            major_done_o,
  output logic            cfg_err_o
);
  logic [NB_W-1:0] byte_q, byte_d, nb_q, byte_sum;
  logic [IT_W-1:0] iter_q, iter_d;
  logic [2:0]      sb_q, sb_in, db_in, sb_m1, db_m1;
  logic            active_q, active_d, err_q, err_d;
  logic            minor_q, minor_d, major_q, major_d;
  logic            bad_cfg, minor_end;

  always_comb begin
    sb_in   = size_bytes(ssize_i);
    db_in   = size_bytes(dsize_i);
    sb_m1   = sb_in - 3'd1;
    db_m1   = db_in - 3'd1;
    bad_cfg = (sb_in == '0) || (db_in == '0) || (nbytes_i == '0) ||
              (iter_i == '0) || ((nbytes_i[1:0] & sb_m1[1:0]) != 2'b00) ||
              ((nbytes_i[1:0] & db_m1[1:0]) != 2'b00);
    adv_o     = xfer_done_i && active_q && !load;
    byte_sum  = byte_q + NB_W'(sb_q);
    minor_end = (byte_sum == nb_q);
    final_o   = adv_o && minor_end && (iter_q == IT_W'(1));
  end

  always_comb begin
    byte_d   = byte_q;
    iter_d   = iter_q;
    active_d = active_q;
    err_d    = err_q;
    minor_d  = 1'b0;
    major_d  = 1'b0;
    if (load) begin
      byte_d   = '0;
      iter_d   = iter_i;
      active_d = !bad_cfg;
      err_d    = bad_cfg;
    end else if (adv_o) begin
      minor_d = minor_end;
      major_d = final_o;
      byte_d  = minor_end ? '0 : byte_sum;
      if (minor_end) iter_d = iter_q - IT_W'(1);
      if (final_o)   active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q   <= '0;
      iter_q   <= '0;
      nb_q     <= '0;
      sb_q     <= '0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
      minor_q  <= 1'b0;
      major_q  <= 1'b0;
    end else begin
      byte_q   <= byte_d;
      iter_q   <= iter_d;
      active_q <= active_d;
      err_q    <= err_d;
      minor_q  <= minor_d;
      major_q  <= major_d;
      if (load) begin
        nb_q <= nbytes_i;
        sb_q <= sb_in;
      end
    end
  end

  assign minor_done_o = minor_q;
  assign major_done_o = major_q;
  assign cfg_err_o    = err_q;

  // R6
  major_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    major_done_o |=> !major_done_o);

  // R6
  major_with_minor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    major_done_o |-> minor_done_o);

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !adv_o);

  // R5
  byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (byte_q < nb_q));
endmodule

// File: rtl/dma_addr_gen.sv
`timescale 1ns/1ps
module dma_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int NB_W   = 16,
  parameter int IT_W   = 16,
  parameter int MOD_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] src_start_i,
  input  logic [1:0]        src_size_i,
  input  logic [OFF_W-1:0]  src_step_i,
  input  logic [MOD_W-1:0]  src_mod_i,
  input  logic [ADDR_W-1:0] src_last_i,
  input  logic [ADDR_W-1:0] dst_start_i,
  input  logic [1:0]        dst_size_i,
  input  logic [OFF_W-1:0]  dst_step_i,
  input  logic [MOD_W-1:0]  dst_mod_i,
  input  logic [ADDR_W-1:0] dst_last_i,
  input  logic [NB_W-1:0]   nbytes_i,
  input  logic [IT_W-1:0]   iter_i,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              minor_done,
  output logic              major_done,
  output logic              cfg_err
);
  localparam int N_SIDE = 2;

  logic              adv, final_x;
  logic [ADDR_W-1:0] start_a [N_SIDE];
  logic [OFF_W-1:0]  step_a  [N_SIDE];
  logic [MOD_W-1:0]  mod_a   [N_SIDE];
  logic [ADDR_W-1:0] last_a  [N_SIDE];
  logic [ADDR_W-1:0] addr_a  [N_SIDE];

  assign start_a[0] = src_start_i;
  assign step_a[0]  = src_step_i;
  assign mod_a[0]   = src_mod_i;
  assign last_a[0]  = src_last_i;
  assign start_a[1] = dst_start_i;
  assign step_a[1]  = dst_step_i;
  assign mod_a[1]   = dst_mod_i;
  assign last_a[1]  = dst_last_i;

  dma_ag_loop #(.NB_W(NB_W), .IT_W(IT_W)) u_loop (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .ssize_i      (src_size_i),
    .dsize_i      (dst_size_i),
    .nbytes_i     (nbytes_i),
    .iter_i       (iter_i),
    .xfer_done_i  (xfer_done),
    .adv_o        (adv),
    .final_o      (final_x),
    .minor_done_o (minor_done),
    .major_done_o (major_done),
    .cfg_err_o    (cfg_err)
  );

  for (genvar g = 0; g < N_SIDE; g++) begin : g_side
    dma_ag_side #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .MOD_W(MOD_W)) u_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .start_i (start_a[g]),
      .step_i  (step_a[g]),
      .mod_i   (mod_a[g]),
      .last_i  (last_a[g]),
      .adv_i   (adv),
      .final_i (final_x),
      .addr_o  (addr_a[g])
    );
  end

  assign src_addr_o = addr_a[0];
  assign dst_addr_o = addr_a[1];

  // R2
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!minor_done && !major_done));
endmodule

// File: tb/sim_dma_addr_gen.sv
`timescale 1ns/1ps
module sim_dma_addr_gen;
  logic        clk, rst_n, load, xfer_done;
  logic [31:0] src_start, src_last, dst_start, dst_last;
  logic [1:0]  src_size, dst_size;
  logic [15:0] src_step, dst_step, nbytes, iter;
  logic [4:0]  src_mod, dst_mod;
  logic [31:0] src_addr, dst_addr;
  logic        minor_done, major_done, cfg_err;
  int          n_chk, n_bad, cyc;
  bit          done_flag;

  dma_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .load(load),
    .src_start_i(src_start), .src_size_i(src_size), .src_step_i(src_step),
    .src_mod_i(src_mod), .src_last_i(src_last),
    .dst_start_i(dst_start), .dst_size_i(dst_size), .dst_step_i(dst_step),
    .dst_mod_i(dst_mod), .dst_last_i(dst_last),
    .nbytes_i(nbytes), .iter_i(iter), .xfer_done(xfer_done),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr),
    .minor_done(minor_done), .major_done(major_done), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      report();
    end
  end

  function automatic logic [31:0] step_model(input logic [31:0] cur,
                                             input logic [15:0] stp,
                                             input int m);
    logic [31:0] s, span;
    s = cur + {{16{stp[15]}}, stp};
    if (m == 0) return s;
    span = 32'd1 << m;
    return ((cur / span) * span) + (s % span);
  endfunction

  task automatic pulse();
    @(negedge clk) xfer_done = 1'b1;
    @(negedge clk) xfer_done = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] sa, input logic [1:0] ss,
                         input logic [15:0] so, input logic [4:0] sm,
                         input logic [31:0] sl, input logic [31:0] da,
                         input logic [1:0] ds, input logic [15:0] dof,
                         input logic [4:0] dm, input logic [31:0] dl,
                         input logic [15:0] nb, input logic [15:0] it);
    @(negedge clk);
    src_start = sa; src_size = ss; src_step = so; src_mod = sm; src_last = sl;
    dst_start = da; dst_size = ds; dst_step = dof; dst_mod = dm; dst_last = dl;
    nbytes = nb; iter = it; load = 1'b1;
    @(negedge clk) load = 1'b0;
  endtask

  initial begin
    logic [31:0] es, ed;
    n_chk = 0; n_bad = 0; cyc = 0; done_flag = 1'b0;
    rst_n = 1'b0; load = 1'b0; xfer_done = 1'b0;
    src_start = '0; src_size = '0; src_step = '0; src_mod = '0; src_last = '0;
    dst_start = '0; dst_size = '0; dst_step = '0; dst_mod = '0; dst_last = '0;
    nbytes = '0; iter = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset src", src_addr, 32'h0);
    chk("R1", "reset dst", dst_addr, 32'h0);
    chk("R1", "reset flags", {29'd0, minor_done, major_done, cfg_err}, 32'h0);
    pulse();
    chk("R1", "idle src", src_addr, 32'h0);
    chk("R1", "idle minor", {31'd0, minor_done}, 32'h0);

    // Sweep: widths x byte counts x iterations x modulo choices
    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++)
        for (int nbi = 0; nbi < 2; nbi++)
          for (int iti = 0; iti < 2; iti++)
            for (int mi = 0; mi < 2; mi++) begin
              int nb, it, per, total, sm, dm;
              logic [15:0] so, dof;
              logic [31:0] sa, da, sl, dl;
              nb = 4 << nbi; it = (iti == 0) ? 1 : 3;
              per = nb >> ss; total = per * it;
              sm = mi ? 4 : 0; dm = mi ? 3 : 0;
              so = 16'(1 << ss); dof = 16'(-(1 << ds));
              sa = 32'h0000_1FF0 + 32'(ss); da = 32'h0000_0004;
              sl = 32'(-(nb * it)); dl = 32'h0000_0100;
              do_load(sa, 2'(ss), so, 5'(sm), sl, da, 2'(ds), dof, 5'(dm), dl,
                      16'(nb), 16'(it));
              chk("R2", "load src", src_addr, sa);
              chk("R2", "load dst", dst_addr, da);
              chk("R8", "legal cfg", {31'd0, cfg_err}, 32'h0);
              es = sa; ed = da;
              for (int t = 1; t <= total; t++) begin
                bit fin, mend;
                fin = (t == total); mend = ((t % per) == 0);
                if (fin) begin
                  es = es + sl;  // R7
                  ed = ed + dl;
                end else begin
                  es = step_model(es, so, sm);  // R3 R4
                  ed = step_model(ed, dof, dm);
                end
                pulse();
                chk(fin ? "R7" : (mi ? "R4" : "R3"), "src", src_addr, es);
                chk(fin ? "R7" : (mi ? "R4" : "R3"), "dst", dst_addr, ed);
                chk("R5", "minor", {31'd0, minor_done}, {31'd0, mend});
                chk("R6", "major", {31'd0, major_done}, {31'd0, fin});
              end
              @(negedge clk);
              chk("R6", "major one cycle", {31'd0, major_done}, 32'h0);
              pulse();
              chk("R9", "after end src", src_addr, es);
              chk("R9", "after end dst", dst_addr, ed);
              chk("R9", "after end minor", {31'd0, minor_done}, 32'h0);
            end

    // Configuration errors (R8) and ignored transfers while in error (R9)
    do_load(32'h40, 2'd2, 16'd4, 5'd0, 32'd0, 32'h80, 2'd0, 16'd1, 5'd0, 32'd0,
            16'd6, 16'd2);
    chk("R8", "nbytes 6 word", {31'd0, cfg_err}, 32'h1);
    pulse();
    chk("R9", "err src hold", src_addr, 32'h40);
    chk("R9", "err dst hold", dst_addr, 32'h80);
    chk("R9", "err minor", {31'd0, minor_done}, 32'h0);
    do_load(32'h40, 2'd1, 16'd2, 5'd0, 32'd0, 32'h80, 2'd1, 16'd2, 5'd0, 32'd0,
            16'd6, 16'd2);
    chk("R8", "nbytes 6 half", {31'd0, cfg_err}, 32'h0);
    pulse();
    chk("R3", "half step src", src_addr, 32'h42);
    do_load(32'h40, 2'd3, 16'd4, 5'd0, 32'd0, 32'h80, 2'd0, 16'd1, 5'd0, 32'd0,
            16'd8, 16'd2);
    chk("R8", "code 3", {31'd0, cfg_err}, 32'h1);
    do_load(32'h40, 2'd0, 16'd1, 5'd0, 32'd0, 32'h80, 2'd2, 16'd4, 5'd0, 32'd0,
            16'd2, 16'd2);
    chk("R8", "dst width", {31'd0, cfg_err}, 32'h1);
    do_load(32'h40, 2'd0, 16'd1, 5'd0, 32'd0, 32'h80, 2'd0, 16'd1, 5'd0, 32'd0,
            16'd4, 16'd0);
    chk("R8", "zero iter", {31'd0, cfg_err}, 32'h1);
    do_load(32'h40, 2'd0, 16'd1, 5'd0, 32'd0, 32'h80, 2'd0, 16'd1, 5'd0, 32'd0,
            16'd0, 16'd1);
    chk("R8", "zero nbytes", {31'd0, cfg_err}, 32'h1);
    pulse();
    chk("R9", "zero nbytes hold", src_addr, 32'h40);

    // Fixed peripheral address: zero step on destination, wrap through zero on source
    do_load(32'h0000_0002, 2'd2, 16'hFFFC, 5'd0, 32'd0, 32'hA000_0010, 2'd2,
            16'd0, 5'd0, 32'd0, 16'd8, 16'd2);
    pulse();
    chk("R3", "wrap below zero", src_addr, 32'hFFFF_FFFE);
    chk("R3", "fixed dst", dst_addr, 32'hA000_0010);
    report();
  end
endmodule